// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block fetches one operand for an accumulator machine. A start pulse carries a 3-bit mode code, a 12-bit operand field and a register selector. The unit works out where the operand lives, reads memory as many times as the mode needs, and writes the result into the accumulator. It reports the effective address it used and pulses done in the cycle the accumulator takes its new value.

Six modes share one state machine. Immediate and register modes finish without touching memory. Direct, register-indirect and indexed modes make one memory read. Indirect mode makes two reads: the first returns a pointer and the second returns the operand. The memory port is synchronous, and its read data is valid the cycle after the memory samples the request. A small register file sits inside the block and is loaded through a write port. One fixed register of that file serves as the implied index register for indexed mode.

Top module: `amf_operand_fetch`

## Requirements
- R1: While rst is high and in the first cycle after it falls, acc, ea, done and mem_rd are all zero.
- R2: Immediate mode (code 0) loads the zero-extended operand field into acc and sets ea to the operand field. It makes no memory read, and done is high in the first cycle after the start edge.
- R3: Direct mode (code 1) sets ea to the operand field and loads mem[operand], with done in the third cycle after the start edge.
- R4: Indirect mode (code 2) reads mem[operand] and takes its low 12 bits as ea. It then loads mem[ea], with done in the fifth cycle after the start edge.
- R5: Register mode (code 3) loads the register named by reg_sel into acc and sets ea to zero. It makes no memory read, and done comes in the first cycle. Registers are written through rf_we/rf_waddr/rf_wdata, and a write takes effect at the clock edge where rf_we is high.
- R6: Register-indirect mode (code 4) takes the low 12 bits of the selected register as ea and loads mem[ea], with done in the third cycle.
- R7: Indexed mode (code 5) sets ea to the operand field plus the low 12 bits of register 1, taken modulo 4096. It loads mem[ea], with done in the third cycle.
- R8: Each mem_rd strobe is high for exactly one cycle. An operation issues exactly one strobe per memory level its mode needs: 0, 1 or 2.
- R9: A start pulse that arrives while an operation is in progress is ignored. The running operation's result, its address and its single done pulse are unaffected.
- R10: done is high for one cycle per operation, and acc changes only in a cycle where done is high.
- R11: The unused mode codes 6 and 7 behave exactly like immediate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 3 | Addressing mode code |
| operand | input | ADDR_W (12) | Operand field of the instruction |
| reg_sel | input | SEL_W (4) | Register selector for register modes |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | SEL_W (4) | Register file write index |
| rf_wdata | input | DATA_W (16) | Register file write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W (12) | Memory read address |
| mem_rdata | input | DATA_W (16) | Memory read data, valid one cycle after the strobe is sampled |
| acc | output | DATA_W (16) | Accumulator |
| ea | output | ADDR_W (12) | Effective address of the last operation |
| done | output | 1 | One-cycle pulse when acc is loaded |

## Verification
The assertions check, on every cycle, the properties that hold at each step. Read strobes last a single cycle. The accumulator is frozen outside done cycles. Immediate mode completes on the very next edge. Direct mode issues its read to the operand address. The second indirect read goes to the pointer just returned. The address is held while a read is waiting. Only the bench's scenarios can show the values and latencies seen from outside: the loaded value, the effective address and the read count for each mode. These cover the worked example across all six modes, wrap-around of the indexed sum, reserved mode codes, and a start pulse dropped in the middle of an indirect fetch.

// File: rtl/amf_pkg.sv
package amf_pkg;
  localparam logic [2:0] AM_IMM  = 3'd0;
  localparam logic [2:0] AM_DIR  = 3'd1;
  localparam logic [2:0] AM_IND  = 3'd2;
  localparam logic [2:0] AM_REG  = 3'd3;
  localparam logic [2:0] AM_RIND = 3'd4;
  localparam logic [2:0] AM_IDX  = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAP  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/amf_regfile.sv
module amf_regfile #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 12,
  parameter int NREG    = 16,
  parameter int IDX_REG = 1,
  localparam int SEL_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] idx_addr
);
  logic [DATA_W-1:0] regs [NREG];

  // one flop bank per register, each cleared on reset
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && waddr == SEL_W'(g))
        regs[g] <= wdata;
    end
  end

  assign rdata    = regs[raddr];
  assign idx_addr = regs[IDX_REG][ADDR_W-1:0];
endmodule

// File: rtl/amf_ea_unit.sv
module amf_ea_unit
  import amf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] idx_addr,
  output logic              needs_mem,
  output logic              two_level,
  output logic [ADDR_W-1:0] first_addr,
  output logic [DATA_W-1:0] direct_val,
  output logic [ADDR_W-1:0] direct_ea
);
  // sum kept at ADDR_W bits so it wraps modulo 2**ADDR_W
  logic [ADDR_W-1:0] idx_sum;
  assign idx_sum = operand + idx_addr;

  always_comb begin
    needs_mem  = 1'b0;
    two_level  = 1'b0;
    first_addr = operand;
    direct_val = DATA_W'(operand);
    direct_ea  = operand;
    case (mode)
      AM_DIR:  needs_mem = 1'b1;
      AM_IND: begin
        needs_mem = 1'b1;
        two_level = 1'b1;
      end
      AM_REG: begin
        direct_val = reg_val;
        direct_ea  = '0;
      end
      AM_RIND: begin
        needs_mem  = 1'b1;
        first_addr = reg_val[ADDR_W-1:0];
      end
      AM_IDX: begin
        needs_mem  = 1'b1;
        first_addr = idx_sum;
      end
      default: ; // immediate and reserved codes
    endcase
  end
endmodule

// File: rtl/amf_ctrl.sv
module amf_ctrl
  import amf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic              needs_mem,
  input  logic              two_level,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [DATA_W-1:0] direct_val,
  input  logic [ADDR_W-1:0] direct_ea,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] ea,
  output logic              done
);
  fetch_state_e state;
  logic         second;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      second   <= 1'b0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      acc      <= '0;
      ea       <= '0;
      done     <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (needs_mem) begin
              mem_rd   <= 1'b1;
              mem_addr <= first_addr;
              ea       <= first_addr;
              second   <= two_level;
              state    <= ST_WAIT;
            end else begin
              acc  <= direct_val;
              ea   <= direct_ea;
              done <= 1'b1;
            end
          end
        end
        ST_WAIT: state <= ST_CAP;
        ST_CAP: begin
          if (second) begin
            mem_rd   <= 1'b1;
            mem_addr <= mem_rdata[ADDR_W-1:0];
            ea       <= mem_rdata[ADDR_W-1:0];
            second   <= 1'b0;
            state    <= ST_WAIT;
          end else begin
            acc   <= mem_rdata;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: read strobe lasts a single cycle
  a_r8_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R10: accumulator moves only together with done
  a_r10_acc_only_on_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(acc));

  // R2: immediate completes on the next edge without a read
  a_r2_imm_next_edge: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && mode == AM_IMM)
      |=> done && !mem_rd && acc == DATA_W'($past(operand)));

  // R3: direct issues its read to the operand address
  a_r3_dir_issue: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && mode == AM_DIR)
      |=> mem_rd && mem_addr == $past(operand));

  // R4: second indirect read targets the returned pointer
  a_r4_ptr_follow: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAP && second)
      |=> mem_rd && mem_addr == $past(mem_rdata[ADDR_W-1:0]));

  // R9: a pending read address is not disturbed by a new start
  a_r9_wait_holds_addr: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |=> $stable(mem_addr) && $stable(ea));
endmodule

// File: rtl/amf_operand_fetch.sv
module amf_operand_fetch #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 12,
  parameter int NREG    = 16,
  parameter int IDX_REG = 1,
  localparam int SEL_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              rf_we,
  input  logic [SEL_W-1:0]  rf_waddr,
  input  logic [DATA_W-1:0] rf_wdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] ea,
  output logic              done
);
  logic [DATA_W-1:0] reg_val;
  logic [ADDR_W-1:0] idx_addr;
  logic              needs_mem;
  logic              two_level;
  logic [ADDR_W-1:0] first_addr;
  logic [DATA_W-1:0] direct_val;
  logic [ADDR_W-1:0] direct_ea;

  amf_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG), .IDX_REG(IDX_REG)
  ) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(reg_sel), .rdata(reg_val), .idx_addr(idx_addr)
  );

  amf_ea_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ea (
    .mode(mode), .operand(operand), .reg_val(reg_val), .idx_addr(idx_addr),
    .needs_mem(needs_mem), .two_level(two_level), .first_addr(first_addr),
    .direct_val(direct_val), .direct_ea(direct_ea)
  );

  amf_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .operand(operand),
    .needs_mem(needs_mem), .two_level(two_level), .first_addr(first_addr),
    .direct_val(direct_val), .direct_ea(direct_ea), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .acc(acc), .ea(ea), .done(done)
  );

  // R1: outputs stay cleared while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      a_r1_reset_quiet: assert (!done && !mem_rd);
    end
  end
endmodule

// File: tb/tb_amf_operand_fetch.sv
`timescale 1ns/1ps
module tb_amf_operand_fetch;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] mode = '0;
  logic [AW-1:0] operand = '0;
  logic [SW-1:0] reg_sel = '0;
  logic rf_we = 1'b0;
  logic [SW-1:0] rf_waddr = '0;
  logic [DW-1:0] rf_wdata = '0;
  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] acc;
  logic [AW-1:0] ea;
  logic done;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mem_m [1 << AW];
  logic [DW-1:0] regs_m [1 << SW];

  always #2.5 clk = ~clk;

  amf_operand_fetch dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .operand(operand),
    .reg_sel(reg_sel), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .acc(acc), .ea(ea), .done(done)
  );

  // synchronous memory model, one cycle read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= mem_m[mem_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6, 3'd7: return "R11";
      default: return "R2";
    endcase
  endfunction

  function automatic void model(input logic [2:0] m, input logic [AW-1:0] op,
                                input logic [SW-1:0] sel, output logic [DW-1:0] v,
                                output logic [AW-1:0] e, output int lat, output int rds);
    case (m)
      3'd1: begin e = op; v = mem_m[e]; lat = 3; rds = 1; end
      3'd2: begin e = mem_m[op][AW-1:0]; v = mem_m[e]; lat = 5; rds = 2; end
      3'd3: begin e = '0; v = regs_m[sel]; lat = 1; rds = 0; end
      3'd4: begin e = regs_m[sel][AW-1:0]; v = mem_m[e]; lat = 3; rds = 1; end
      3'd5: begin e = op + regs_m[1][AW-1:0]; v = mem_m[e]; lat = 3; rds = 1; end
      default: begin e = op; v = DW'(op); lat = 1; rds = 0; end
    endcase
  endfunction

  task automatic wr_reg(input logic [SW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
    regs_m[a] = d;
  endtask

  // issue one op; optionally pulse start again while busy
  task automatic run_op(input logic [2:0] m, input logic [AW-1:0] op,
                        input logic [SW-1:0] sel, input bit poke);
    logic [DW-1:0] ev;
    logic [AW-1:0] ee;
    int el, er, lat, rds, dones;
    string rq;
    model(m, op, sel, ev, ee, el, er);
    rq = req_of(m);
    @(negedge clk);
    start = 1'b1; mode = m; operand = op; reg_sel = sel;
    @(negedge clk);
    start = 1'b0;
    lat = 1; rds = 0; dones = 0;
    forever begin
      if (mem_rd) rds++;
      if (done) break;
      if (lat > 20) break;
      if (poke && lat == 1) begin
        start = 1'b1; mode = 3'd0; operand = ~op;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(acc == ev, rq, "acc", 32'(acc), 32'(ev));
    chk(ea == ee, rq, "ea", 32'(ea), 32'(ee));
    chk(lat == el, rq, "latency", 32'(lat), 32'(el));
    chk(rds == er, "R8", "read count", 32'(rds), 32'(er));
    @(negedge clk);
    chk(!done, "R10", "done width", 32'(done), 32'd0);
    if (poke) begin
      for (int i = 0; i < 8; i++) begin
        if (done) dones++;
        @(negedge clk);
      end
      chk(dones == 0, "R9", "extra done", 32'(dones), 32'd0);
      chk(acc == ev, "R9", "acc after ignored start", 32'(acc), 32'(ev));
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < (1 << AW); i++) mem_m[i] = DW'($urandom);
    for (int i = 0; i < (1 << SW); i++) regs_m[i] = '0;
    repeat (3) @(negedge clk);
    chk(acc == 0 && ea == 0 && !done && !mem_rd, "R1", "outputs in reset",
        {acc, 4'(ea), 3'b0, done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(acc == 0 && ea == 0 && !done && !mem_rd, "R1", "outputs after reset",
        {acc, 4'(ea), 3'b0, done}, 32'd0);

    // worked example across all six modes
    mem_m[800] = 16'd900; mem_m[900] = 16'd1000; mem_m[1600] = 16'd700;
    wr_reg(4'd1, 16'd800);
    run_op(3'd0, 12'd800, 4'd1, 1'b0);
    chk(acc == 16'd800, "R2", "example immediate", 32'(acc), 32'd800);
    run_op(3'd1, 12'd800, 4'd1, 1'b0);
    chk(acc == 16'd900, "R3", "example direct", 32'(acc), 32'd900);
    run_op(3'd2, 12'd800, 4'd1, 1'b0);
    chk(acc == 16'd1000, "R4", "example indirect", 32'(acc), 32'd1000);
    run_op(3'd5, 12'd800, 4'd1, 1'b0);
    chk(acc == 16'd700, "R7", "example indexed", 32'(acc), 32'd700);
    run_op(3'd3, 12'd800, 4'd1, 1'b0);
    chk(acc == 16'd800, "R5", "example register", 32'(acc), 32'd800);
    run_op(3'd4, 12'd800, 4'd1, 1'b0);
    chk(acc == 16'd900, "R6", "example register-indirect", 32'(acc), 32'd900);

    // indexed sum wraps at 4096: 4000 + 200 -> 104
    wr_reg(4'd1, 16'd200);
    mem_m[104] = 16'hBEEF;
    run_op(3'd5, 12'd4000, 4'd0, 1'b0);
    chk(ea == 12'd104, "R7", "wrapped ea", 32'(ea), 32'd104);

    // reserved codes act as immediate
    run_op(3'd6, 12'hABC, 4'd2, 1'b0);
    run_op(3'd7, 12'h0FF, 4'd3, 1'b0);

    // start pulses during busy operations are dropped
    run_op(3'd2, 12'd800, 4'd0, 1'b1);
    run_op(3'd1, 12'd77, 4'd0, 1'b1);

    // constrained random mix
    for (int n = 0; n < 200; n++) begin
      if ($urandom_range(0, 3) == 0)
        wr_reg(SW'($urandom_range(0, 15)), DW'($urandom));
      run_op(3'($urandom_range(0, 7)), AW'($urandom), SW'($urandom_range(0, 15)),
             ($urandom_range(0, 7) == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule